// File: doc/BRIEF.md
# Four-Channel DMA Interrupt Flag Controller

This block holds the interrupt state of four DMA channels (receive A, transmit A, receive B, transmit B). Each channel keeps two flags: a pending flag (IP), which notes that the channel has an interrupt to report, and an in-service flag (IUS), which notes that the host is currently handling it. A channel's event pulse sets its pending flag. The host changes the flags by writing one command byte. That byte holds an operation code and a channel mask, so one write can change several channels at once. Reading the same address returns all eight flags.

The block raises a combined interrupt request whenever an enabled, pending, not-in-service channel exists and the request gates are open. It also takes part in a priority daisy chain. An enable input from the higher-priority neighbour gates everything, and an enable output passes permission on to lower-priority devices. A separate input reports that a higher-priority peer cell on the same device has its own interrupt pending. When the host acknowledges an interrupt, the block marks the single highest-priority eligible channel as in service. A two-bit input selects one of four fixed channel orderings for that choice.

The write port, the status read and the chain signals are plain control and status pins. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. A write strobe is accepted on every cycle in which it is high.

Top module: `dmairq_top`

## Requirements
- R1: After reset every IP and IUS flag is 0, so `rd_data` reads 8'h00 and `irq_req` is 0.
- R2: A write takes effect at the clock edge where `wr_en` is high. Bits 7:5 of `wr_data` form the code. Code bit 0 selects the IP flags and code bit 1 selects the IUS flags. Code bit 2 chooses set (1) or clear (0). So the codes map as follows: 001 clears IP, 010 clears IUS, 011 clears both, 101 sets IP, 110 sets IUS and 111 sets both. Codes 000 and 100 change nothing, and bit 4 is ignored.
- R3: Bits 3:0 of `wr_data` are the channel mask: bit 3 is Rx A, bit 2 is Tx A, bit 1 is Rx B and bit 0 is Tx B. The command acts on every channel whose bit is set. The mask is not kept, so a later write with mask 0 changes nothing.
- R4: `rd_data` is combinational from the flags and is laid out as {IUS[3:0], IP[3:0]}. Within each nibble, bit 3 is Rx A, bit 2 is Tx A, bit 1 is Rx B and bit 0 is Tx B.
- R5: A high `evt[i]` sets IP of channel i at the next edge. If it coincides with a clear-IP command on the same channel, the flag still ends up set.
- R6: `irq_req` is combinational and is 1 exactly when some channel has IP=1, `chan_en`=1 and IUS=0 while `master_en` and `chain_in` are both 1.
- R7: At an edge where `ack` is high, a channel is eligible when it has IP=1 and `chan_en`=1, with `master_en`=1, `chain_in`=1 and `peer_pend`=0. IUS is set on the one highest-priority eligible channel, or on no channel if none is eligible. IP is left unchanged. An acknowledge set beats a clear-IUS command in the same cycle.
- R8: `prio_sel` selects the order used by R7, highest priority first. 0 gives Rx A, Tx A, Rx B, Tx B. 1 gives Rx A, Rx B, Tx A, Tx B. 2 gives Rx B, Tx B, Rx A, Tx A. 3 gives Tx B, Rx B, Tx A, Rx A.
- R9: `chain_out` is combinational. It is 0 when `chain_in` is 0, when any IUS flag is 1, or when `ack` is high while some channel has IP=1 and `chan_en`=1 with `master_en`=1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte: code 7:5, bit 4 ignored, mask 3:0 |
| rd_data | output | 8 | Flag status {IUS[3:0], IP[3:0]} |
| evt | input | 4 | Per-channel interrupt event pulses |
| chan_en | input | 4 | Per-channel interrupt enables |
| master_en | input | 1 | Master interrupt enable |
| prio_sel | input | 2 | Channel priority ordering select |
| chain_in | input | 1 | Daisy-chain enable from the higher-priority device |
| peer_pend | input | 1 | Higher-priority peer cell has an interrupt pending |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq_req | output | 1 | Combined interrupt request |
| chain_out | output | 1 | Daisy-chain enable to lower-priority devices |

## Verification
`irq_req`, `chain_out` and `rd_data` follow the inputs and flags within the same cycle. Flag changes from writes, events and acknowledges appear one clock edge after the stimulus. The bench drives every input on the falling edge and checks the combinational outputs 1 ns later against its own model of the current flags. It then steps its model at the rising edge and compares the updated flags at the next falling edge, so each result is sampled in the cycle where it is due. Directed cases compare against literal byte values for the reserved code, mask reuse, event-versus-clear collisions, all four orderings and acknowledge-versus-clear collisions.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);

  typedef enum logic [1:0] {
    ORD_DEFAULT  = 2'd0,
    ORD_RX_FIRST = 2'd1,
    ORD_B_FIRST  = 2'd2,
    ORD_REVERSE  = 2'd3
  } order_e;

  typedef struct packed {
    logic [NCH-1:0] set_ip;
    logic [NCH-1:0] clr_ip;
    logic [NCH-1:0] set_ius;
    logic [NCH-1:0] clr_ius;
  } cmd_t;

  // channel index holding a given rank (rank 0 = highest priority)
  function automatic logic [CW-1:0] rank_chan(order_e ord, int rank);
    logic [CW-1:0] ch;
    case (ord)
      ORD_RX_FIRST: case (rank)
        0: ch = CW'(3);
        1: ch = CW'(1);
        2: ch = CW'(2);
        default: ch = CW'(0);
      endcase
      ORD_B_FIRST: case (rank)
        0: ch = CW'(1);
        1: ch = CW'(0);
        2: ch = CW'(3);
        default: ch = CW'(2);
      endcase
      ORD_REVERSE: ch = CW'(rank);
      default:     ch = CW'(NCH - 1 - rank);
    endcase
    return ch;
  endfunction
endpackage

// File: rtl/dmairq_cmd_dec.sv
module dmairq_cmd_dec
  import dmairq_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output cmd_t       cmd
);
  localparam int CODE_LSB = 5;

  logic [2:0]   code;
  logic [N-1:0] mask;
  logic         do_set, do_clr;
  logic         unused_rsv_bit;

  assign code           = wr_data[CODE_LSB +: 3];
  assign mask           = wr_data[N-1:0];
  assign unused_rsv_bit = wr_data[4];
  assign do_set         = wr_en &  code[2];
  assign do_clr         = wr_en & ~code[2];

  always_comb begin
    cmd.set_ip  = (do_set & code[0]) ? mask : '0;
    cmd.clr_ip  = (do_clr & code[0]) ? mask : '0;
    cmd.set_ius = (do_set & code[1]) ? mask : '0;
    cmd.clr_ius = (do_clr & code[1]) ? mask : '0;
  end
endmodule

// File: rtl/dmairq_flags.sv
module dmairq_flags
  import dmairq_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cmd_t         cmd,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ack_set,
  output logic [N-1:0] ip,
  output logic [N-1:0] ius
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic r_ip, r_ius;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_ip  <= 1'b0;
        r_ius <= 1'b0;
      end else begin
        // sets are ORed after the clear so an event or acknowledge wins
        r_ip  <= (r_ip  & ~cmd.clr_ip[i])  | cmd.set_ip[i]  | evt[i];
        r_ius <= (r_ius & ~cmd.clr_ius[i]) | cmd.set_ius[i] | ack_set[i];
      end
    end

    assign ip[i]  = r_ip;
    assign ius[i] = r_ius;

    AST_EVT_SETS_IP: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> ip[i]); // R5
    AST_CLR_IP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.clr_ip[i] && !evt[i]) |=> !ip[i]); // R2
    AST_ACK_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_set[i] |=> ius[i]); // R7
  end
endmodule

// File: rtl/dmairq_arb.sv
module dmairq_arb
  import dmairq_pkg::*;
#(
  parameter int N = NCH
) (
  input  order_e       ord,
  input  logic [N-1:0] elig,
  output logic [N-1:0] win
);
  localparam int W = $clog2(N);

  logic         found;
  logic [W-1:0] ch;

  always_comb begin
    win   = '0;
    found = 1'b0;
    ch    = '0;
    for (int r = 0; r < N; r++) begin
      ch = rank_chan(ord, r);
      if (!found && elig[ch]) begin
        win[ch] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  output logic [7:0]     rd_data,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] chan_en,
  input  logic           master_en,
  input  logic [1:0]     prio_sel,
  input  logic           chain_in,
  input  logic           peer_pend,
  input  logic           ack,
  output logic           irq_req,
  output logic           chain_out
);
  cmd_t           cmd;
  logic [NCH-1:0] ip, ius;
  logic [NCH-1:0] pend_en, elig, win, ack_set;
  logic           gates_open;

  dmairq_cmd_dec #(.N(NCH)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  assign pend_en    = ip & chan_en & {NCH{master_en}};
  assign gates_open = chain_in & ~peer_pend;
  assign elig       = pend_en & {NCH{gates_open}};

  dmairq_arb #(.N(NCH)) u_arb (
    .ord  (order_e'(prio_sel)),
    .elig (elig),
    .win  (win)
  );

  assign ack_set = win & {NCH{ack}};

  dmairq_flags #(.N(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .evt     (evt),
    .ack_set (ack_set),
    .ip      (ip),
    .ius     (ius)
  );

  assign rd_data   = {ius, ip};
  assign irq_req   = chain_in & (|(pend_en & ~ius));
  assign chain_out = chain_in & ~(|ius) & ~(ack & (|pend_en));

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($onehot0(win) && ((win & ~elig) == '0))); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en) |=> ($countones(ius & ~$past(ius)) <= 1)); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (chain_in && master_en)); // R6
  AST_EO_IUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius) |-> !chain_out); // R9
  AST_RSV_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:5] == 3'b100 && evt == '0 && !ack)
      |=> ($stable(ip) && $stable(ius))); // R2
endmodule

// File: tb/dmairq_top_bench.sv
module dmairq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] evt = '0;
  logic [3:0] chan_en = '0;
  logic       master_en = 1'b0;
  logic [1:0] prio_sel = '0;
  logic       chain_in = 1'b0;
  logic       peer_pend = 1'b0;
  logic       ack = 1'b0;
  logic       irq_req, chain_out;

  int n_chk = 0;
  int n_err = 0;
  logic [3:0] m_ip = '0, m_ius = '0;

  always #10 clk = ~clk;

  dmairq_top u_dmairq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .evt(evt), .chan_en(chan_en), .master_en(master_en), .prio_sel(prio_sel),
    .chain_in(chain_in), .peer_pend(peer_pend), .ack(ack),
    .irq_req(irq_req), .chain_out(chain_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // priority list, highest first, two bits per rank from the top
  function automatic logic [7:0] order_list(input logic [1:0] sel);
    case (sel)
      2'd0: return {2'd3, 2'd2, 2'd1, 2'd0};
      2'd1: return {2'd3, 2'd1, 2'd2, 2'd0};
      2'd2: return {2'd1, 2'd0, 2'd3, 2'd2};
      default: return {2'd0, 2'd1, 2'd2, 2'd3};
    endcase
  endfunction

  function automatic logic [3:0] exp_win(input logic [3:0] ip, input logic [3:0] en,
                                         input logic me, input logic ci, input logic pp,
                                         input logic [1:0] sel);
    logic [7:0] lst;
    logic [3:0] elig;
    lst  = order_list(sel);
    elig = ip & en & {4{me & ci & ~pp}};
    for (int r = 0; r < 4; r++) begin
      logic [1:0] c;
      c = lst[7 - 2*r -: 2];
      if (elig[c]) return 4'b0001 << c;
    end
    return 4'b0000;
  endfunction

  function automatic logic exp_irq();
    return master_en & chain_in & (|(m_ip & chan_en & ~m_ius));
  endfunction

  function automatic logic exp_eo();
    if (!chain_in || (|m_ius)) return 1'b0;
    if (ack && master_en && (|(m_ip & chan_en))) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_step();
    logic [2:0] code;
    logic [3:0] msk, sip, cip, sius, cius, w;
    code = wr_data[7:5];
    msk  = wr_data[3:0];
    sip  = (wr_en &&  code[2] && code[0]) ? msk : 4'b0;
    cip  = (wr_en && !code[2] && code[0]) ? msk : 4'b0;
    sius = (wr_en &&  code[2] && code[1]) ? msk : 4'b0;
    cius = (wr_en && !code[2] && code[1]) ? msk : 4'b0;
    w    = ack ? exp_win(m_ip, chan_en, master_en, chain_in, peer_pend, prio_sel) : 4'b0;
    m_ip  = (m_ip & ~cip) | sip | evt;
    m_ius = (m_ius & ~cius) | sius | w;
  endtask

  // inputs already set at the falling edge; check outputs, cross the edge, update model
  task automatic tick();
    #1;
    chk("R4 status", rd_data, {m_ius, m_ip});
    chk("R6 irq", {7'd0, irq_req}, {7'd0, exp_irq()});
    chk("R9 chain_out", {7'd0, chain_out}, {7'd0, exp_eo()});
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 1'b0; evt = '0; ack = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    chain_in = 1'b1; master_en = 1'b1; chan_en = 4'hF;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", rd_data, 8'h00);
    chk("R1 reset irq", {7'd0, irq_req}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    tick();

    // R2 / R3: set both everywhere, clear both with bit 4 high
    wr(8'hEF); chk("R2 set both all", rd_data, 8'hFF);
    wr(8'h7F); chk("R2 clear both, bit4 ignored", rd_data, 8'h00);
    wr(8'hAA); chk("R3 set IP RxA+RxB", rd_data, 8'h0A);
    wr(8'h8F); chk("R2 reserved code 100", rd_data, 8'h0A);
    wr(8'h0F); chk("R2 code 000", rd_data, 8'h0A);
    wr(8'hA4); chk("R3 set IP TxA", rd_data, 8'h0E);
    wr(8'h20); chk("R3 mask not stored", rd_data, 8'h0E);
    wr(8'hC5); chk("R2 set IUS TxA TxB", rd_data, 8'h5E);
    wr(8'h44); chk("R2 clear IUS TxA", rd_data, 8'h1E);
    wr(8'h7F);

    // R5: event beats clear-IP on the same channel
    evt = 4'b0001; wr(8'h21);
    chk("R5 event wins over clear", rd_data, 8'h01);
    evt = 4'b1000; tick();
    chk("R5 event sets IP", rd_data, 8'h09);
    wr(8'h7F);

    // R6: request gating
    chan_en = 4'b0010; wr(8'hA2);
    #1 chk("R6 irq when enabled", {7'd0, irq_req}, 8'h01);
    chain_in = 1'b0;
    #1 chk("R6 irq blocked by chain_in", {7'd0, irq_req}, 8'h00);
    chk("R9 chain_out low with chain_in low", {7'd0, chain_out}, 8'h00);
    chain_in = 1'b1;
    wr(8'hC2);
    #1 chk("R6 irq blocked by IUS", {7'd0, irq_req}, 8'h00);
    chk("R9 chain_out low with IUS", {7'd0, chain_out}, 8'h00);
    @(negedge clk);
    wr(8'h7F);

    // R7 / R8: one winner per ordering
    chan_en = 4'hF;
    for (int s = 0; s < 4; s++) begin
      logic [7:0] e;
      prio_sel = s[1:0];
      wr(8'hAF);
      ack = 1'b1;
      #1 chk("R9 chain_out low during ack", {7'd0, chain_out}, 8'h00);
      tick();
      case (s)
        0, 1:    e = 8'h8F;
        2:       e = 8'h2F;
        default: e = 8'h1F;
      endcase
      chk("R8 ack winner per ordering", rd_data, e);
      wr(8'h7F);
    end
    prio_sel = 2'd1; chan_en = 4'b0111; wr(8'hAF);
    ack = 1'b1; tick();
    chk("R8 disabled channel skipped", rd_data, 8'h2F);
    wr(8'h7F);
    chan_en = 4'hF; peer_pend = 1'b1; wr(8'hAF);
    ack = 1'b1; tick();
    chk("R7 peer pending blocks ack", rd_data, 8'h0F);
    peer_pend = 1'b0;
    prio_sel = 2'd0; wr(8'h7F); wr(8'hE8); // RxA IP and IUS set
    ack = 1'b1; wr(8'h48);
    chk("R7 ack beats clear IUS", rd_data, 8'h88);
    wr(8'h7F);

    // random phase
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r;
      r = $urandom;
      wr_en     = (r[3:0] < 4'd5);
      wr_data   = $urandom;
      evt       = (r[6:4] == 3'd0) ? 4'($urandom) : 4'b0;
      ack       = (r[9:7] < 3'd2);
      chan_en   = 4'($urandom);
      master_en = (r[12:10] != 3'd0);
      chain_in  = (r[15:13] != 3'd0);
      peer_pend = (r[18:16] == 3'd0);
      prio_sel  = r[20:19];
      tick();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule